// File: doc/BRIEF.md
# DDR Bank State Tracker and Command Checker

This block watches a stream of already decoded DDR SDRAM commands and keeps a shadow of the state of every bank. For each bank it records whether a row is open and which row it is. Each command is judged against that shadow. An illegal command raises a one-cycle error pulse with a reason code and leaves the state untouched. A precharge that finds nothing to close is reported as a no-op.

The block also follows the single shared data burst. This lets it close a bank whose read or write carried auto-precharge, and lets it judge a burst-terminate command. It sits beside a memory controller or on a bus monitor as a protocol checker. Analog timing, the data path and refresh are outside its view.

Top module: `ddr_bank_tracker`

## Requirements
- R1: When `cmd_vld` is high, `cmd`=3 (activate) to an idle bank `ba` sets `bank_open[ba]` at that clock edge. The row slice `open_row[ba*ROW_W +: ROW_W]` then equals `addr`.
- R2: An activate to a bank that already has an open row gives `err`=1 with `err_code`=1 and changes no state.
- R3: A read (`cmd`=4) or write (`cmd`=5) to an idle bank gives `err`=1 with `err_code`=2 and changes no state.
- R4: A legal read or write with `addr[10]`=0 leaves its bank open. With `addr[10]`=1 the bank closes at the clock edge that comes BURST_LEN/2 edges after the command edge.
- R5: A precharge (`cmd`=6) with `addr[10]`=1 closes every bank and ignores `ba`. With `addr[10]`=0 it closes only bank `ba`.
- R6: A precharge that targets an idle bank, a bank whose auto-precharge is still pending, or all banks when none is open raises `noop`=1 with no error and no state change.
- R7: Load mode (`cmd`=2) is legal only while every bank is idle. Otherwise it gives `err_code`=3. It never changes bank state.
- R8: Burst terminate (`cmd`=7) during a read issued without auto-precharge ends that burst and keeps its row open, with no error. With no read in flight, or with a write in flight, it gives `err_code`=4. During an auto-precharge read it gives `err_code`=5.
- R9: A read or write issued while an auto-precharge burst is still in flight gives `err_code`=6 and changes no state.
- R10: Deselect (`cmd`=0), NOP (`cmd`=1), and any command with `cmd_vld` low change no state and raise neither `err` nor `noop`.
- R11: While `rst_n` is low, all banks are idle and `err`, `err_code` and `noop` are zero.
- R12: `err`, `err_code` and `noop` are registered. They are valid for exactly the one cycle after the command edge, and `err` and `noop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe |
| cmd | input | 3 | Command code (0 deselect, 1 NOP, 2 load mode, 3 activate, 4 read, 5 write, 6 precharge, 7 burst terminate) |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address, or column address with auto/all flag on bit 10 |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_row | output | 52 | Open-row register of each bank, bank b in bits b*13 +: 13 |
| err | output | 1 | Illegal command pulse |
| err_code | output | 3 | Reason for the error (0 when none) |
| noop | output | 1 | Command treated as a no-op pulse |

## Verification
A wrong open flag shows up on `bank_open` one cycle after the command edge that corrupted it. It also shows up again later as a wrong verdict on the next command aimed at that bank: a spurious code 1 or code 2, or a missing no-op. A lost burst counter shows up as an auto-precharge bank that closes early, closes late or never closes. It also shows up as a burst terminate that is judged wrongly. The bench compares every output on every cycle against a model written from the requirements. Each fault is therefore caught in the first cycle it becomes visible.

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int NBANK     = 4,
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_vld,
  input  logic [2:0]             cmd,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_row,
  output logic                   err,
  output logic [2:0]             err_code,
  output logic                   noop
);
  localparam int BC   = BURST_LEN / 2;
  localparam int CW   = $clog2(BC + 1);
  localparam int FLAG = 10;

  typedef enum logic [2:0] {
    C_DES = 3'd0, C_NOP = 3'd1, C_LMR = 3'd2, C_ACT = 3'd3,
    C_RD  = 3'd4, C_WR  = 3'd5, C_PRE = 3'd6, C_BT  = 3'd7
  } cmd_e;

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q [NBANK];
  logic [CW-1:0]    cnt_q;
  logic [BA_W-1:0]  bank_q;
  logic             ap_q, rd_q;

  logic       ap_busy, sel_open, any_open;
  logic       act_ok, rw_ok, pre_one, pre_all, bt_cut, noop_n;
  logic [2:0] code_n;

  assign ap_busy  = (cnt_q != '0) && ap_q;
  assign sel_open = open_q[ba];
  assign any_open = |open_q;

  always_comb begin
    act_ok = 1'b0; rw_ok = 1'b0; pre_one = 1'b0; pre_all = 1'b0;
    bt_cut = 1'b0; noop_n = 1'b0; code_n = 3'd0;
    if (cmd_vld) begin
      case (cmd_e'(cmd))
        C_ACT: if (sel_open) code_n = 3'd1; else act_ok = 1'b1;
        C_RD, C_WR: begin
          if (!sel_open)    code_n = 3'd2;
          else if (ap_busy) code_n = 3'd6;
          else              rw_ok  = 1'b1;
        end
        C_PRE: begin
          if (addr[FLAG]) begin
            if (any_open) pre_all = 1'b1; else noop_n = 1'b1;
          end else if (!sel_open || (ap_busy && bank_q == ba)) noop_n = 1'b1;
          else pre_one = 1'b1;
        end
        C_LMR: if (any_open) code_n = 3'd3;
        C_BT: begin
          if (cnt_q == '0 || !rd_q) code_n = 3'd4;
          else if (ap_q)            code_n = 3'd5;
          else                      bt_cut = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0; cnt_q <= '0; bank_q <= '0; ap_q <= 1'b0; rd_q <= 1'b0;
      err <= 1'b0; err_code <= 3'd0; noop <= 1'b0;
      for (int i = 0; i < NBANK; i++) row_q[i] <= '0;
    end else begin
      err      <= code_n != 3'd0;
      err_code <= code_n;
      noop     <= noop_n;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1) && ap_q) open_q[bank_q] <= 1'b0;
      if (act_ok) begin
        open_q[ba] <= 1'b1;
        row_q[ba]  <= addr;
      end
      if (rw_ok) begin
        cnt_q  <= CW'(BC);
        bank_q <= ba;
        ap_q   <= addr[FLAG];
        rd_q   <= cmd == C_RD;
      end
      if (bt_cut)  cnt_q <= '0;
      if (pre_one) open_q[ba] <= 1'b0;
      if (pre_all) begin
        open_q <= '0;
        ap_q   <= 1'b0;
      end
    end
  end

  assign bank_open = open_q;
  for (genvar g = 0; g < NBANK; g++) begin : g_row
    assign open_row[g*ROW_W +: ROW_W] = row_q[g];
  end

  a_r1_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd == C_ACT && !open_q[ba]
    |=> open_q[$past(ba)] && row_q[$past(ba)] == $past(addr));
  a_r2_act_twice: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd == C_ACT && open_q[ba] |=> err && err_code == 3'd1);
  a_r3_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && (cmd == C_RD || cmd == C_WR) && !open_q[ba]
    |=> err && err_code == 3'd2);
  a_r5_close_all: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd == C_PRE && addr[FLAG] |=> open_q == '0);
  a_r7_mode_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd == C_LMR && open_q != '0 |=> err && err_code == 3'd3);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld || cmd == C_DES || cmd == C_NOP |=> !err && !noop);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && noop));
endmodule

// File: tb/ddr_bank_tracker_tb.sv
`timescale 1ns/1ps
module ddr_bank_tracker_tb;
  localparam int BC = 2;
  logic        clk = 1'b0, rst_n = 1'b0, cmd_vld = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic [3:0]  bank_open;
  logic [51:0] open_row;
  logic        err, noop;
  logic [2:0]  err_code;

  ddr_bank_tracker u_dut (.clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd),
    .ba(ba), .addr(addr), .bank_open(bank_open), .open_row(open_row),
    .err(err), .err_code(err_code), .noop(noop));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit          m_open [4];
  logic [12:0] m_row [4];
  int mcnt = 0, mbank = 0;
  bit map = 0, mread = 0, prev_pulse = 0;
  int e_code; bit e_noop; string e_tag;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [12:0] rowof(input int b);
    return 13'(b * 13'h0a5 + 3);
  endfunction

  task automatic model(input bit v, input logic [2:0] c, input int b, input logic [12:0] a);
    bit anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    bit apb = (mcnt != 0) && map;
    int ocnt = mcnt; bit ord = mread; bit oap = map;
    e_code = 0; e_noop = 0; e_tag = "R10";
    if (mcnt != 0) mcnt--;
    if (ocnt == 1 && oap) begin m_open[mbank] = 0; e_tag = "R4"; end
    if (v) case (c)
      3'd3: begin e_tag = m_open[b] ? "R2" : "R1";
              if (m_open[b]) e_code = 1; else begin m_open[b] = 1; m_row[b] = a; end end
      3'd4, 3'd5: begin
              if (!m_open[b]) begin e_code = 2; e_tag = "R3"; end
              else if (apb) begin e_code = 6; e_tag = "R9"; end
              else begin mcnt = BC; mbank = b; map = a[10]; mread = (c == 3'd4); e_tag = "R4"; end end
      3'd6: begin
              if (a[10]) begin
                if (!anyo) begin e_noop = 1; e_tag = "R6"; end
                else begin for (int i = 0; i < 4; i++) m_open[i] = 0; map = 0; e_tag = "R5"; end
              end else if (!m_open[b] || (apb && mbank == b)) begin e_noop = 1; e_tag = "R6"; end
              else begin m_open[b] = 0; e_tag = "R5"; end end
      3'd2: begin e_tag = "R7"; if (anyo) e_code = 3; end
      3'd7: begin e_tag = "R8";
              if (ocnt == 0 || !ord) e_code = 4;
              else if (oap) e_code = 5;
              else mcnt = 0; end
      default: ;
    endcase
  endtask

  task automatic compare();
    string pt = prev_pulse ? "R12" : e_tag;
    check(err == (e_code != 0), pt, "err", err, e_code != 0);
    check(err_code == 3'(e_code), pt, "err_code", err_code, e_code);
    check(noop == e_noop, pt, "noop", noop, e_noop);
    check(!(err && noop), "R12", "err&noop", {err, noop}, 0);
    for (int i = 0; i < 4; i++) begin
      check(bank_open[i] == m_open[i], e_tag, $sformatf("bank_open[%0d]", i), bank_open[i], m_open[i]);
      if (m_open[i]) check(open_row[i*13 +: 13] == m_row[i], e_tag, $sformatf("open_row[%0d]", i),
                           open_row[i*13 +: 13], m_row[i]);
    end
    prev_pulse = (e_code != 0) || e_noop;
  endtask

  task automatic tick(input bit v, input logic [2:0] c, input int b, input logic [12:0] a);
    cmd_vld = v; cmd = c; ba = b[1:0]; addr = a;
    @(posedge clk);
    model(v, c, b, a);
    @(negedge clk);
    cmd_vld = 1'b0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 3'd0, 0, 13'd0);
  endtask

  task automatic reopen();
    for (int i = 0; i < 4; i++) if (!m_open[i]) tick(1, 3'd3, i, rowof(i));
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) m_open[i] = 0;
    mcnt = 0; map = 0; mread = 0; prev_pulse = 0;
    check(bank_open == 4'd0, "R11", "bank_open", bank_open, 0);
    check(!err && err_code == 3'd0 && !noop, "R11", "err/code/noop", {err, err_code, noop}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    reset_check();
    // sweep from all idle
    for (int c = 0; c < 8; c++) for (int b = 0; b < 4; b++) for (int f = 0; f < 2; f++) begin
      tick(1, 3'(c), b, rowof(b) | (f ? 13'h400 : 13'h000));
      tick(1, 3'd6, 0, 13'h400);
      idle(3);
    end
    // sweep from all open
    reopen();
    for (int c = 0; c < 8; c++) for (int b = 0; b < 4; b++) for (int f = 0; f < 2; f++) begin
      tick(1, 3'(c), b, (f ? 13'h400 : 13'h000) | 13'h00c);
      idle(3);
      reopen();
    end
    // R4 auto-precharge timing, R9 and R8 during it, R6 on pending bank
    tick(1, 3'd4, 1, 13'h404); tick(1, 3'd5, 2, 13'h010); idle(2); reopen();
    tick(1, 3'd5, 3, 13'h400); tick(1, 3'd7, 0, 13'h0); idle(2); reopen();
    tick(1, 3'd4, 0, 13'h400); tick(1, 3'd7, 0, 13'h0); idle(2); reopen();
    tick(1, 3'd4, 2, 13'h400); tick(1, 3'd6, 2, 13'h000); idle(2); reopen();
    tick(1, 3'd4, 2, 13'h400); tick(1, 3'd6, 0, 13'h400); idle(2); reopen();
    // R8 truncation and back-to-back bursts
    tick(1, 3'd4, 1, 13'h020); tick(1, 3'd7, 3, 13'h0); tick(1, 3'd7, 3, 13'h0); idle(1);
    tick(1, 3'd4, 1, 13'h020); tick(1, 3'd4, 2, 13'h030); tick(1, 3'd5, 3, 13'h400); idle(3); reopen();
    // R10 strobe low with every code
    for (int c = 0; c < 8; c++) tick(0, 3'(c), c % 4, 13'h400);
    reset_check();
    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule